// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Flags

This block holds one byte-wide register that collects four external interrupt sources. Each source has its own pin. The pin is brought into the clock domain through a two-flop synchronizer, then an edge detector watches it. When the detector sees an edge of the right direction, it sets a flag, and the flag stays set. The direction alternates from source to source. Two sources respond to a rising edge and two respond to a falling edge.

The register sits on a simple special-function bus at address 0x91. Software reads the four flags in the upper nibble. A write loads the upper nibble directly, so software clears a flag by writing 0 to it. Software raises a flag by writing 1 to it. A flag raised by software requests an interrupt in exactly the same way as a flag raised by a pin edge. Each flag is ANDed with an enable input of its own and then registered to form the request output.

The lower nibble is not stored here. It reads back whatever value the external clock-control logic supplies. Vectoring and priority between requests are handled elsewhere.

Top module: `extIrqFlags`

## Requirements
- R1: While reset is asserted, and immediately after it is released, all four flags are 0 and all four request outputs are 0.
- R2: Sources at flag bit 4 (pin index 0) and bit 6 (pin index 2) respond to rising edges. The first clock edge that samples the pin high after it was low is edge k. The flag is set at clock edge k+2.
- R3: Sources at flag bit 5 (pin index 1) and bit 7 (pin index 3) respond to falling edges, with the same timing as in R2.
- R4: A pin edge in the opposite direction has no effect on its flag, and the read value shows no change.
- R5: Hardware never clears a flag. A set flag stays set until software writes 0 to it.
- R6: A write to address 0x91 loads data bits 7:4 into the flags at that clock edge. A 1 sets the flag and a 0 clears it. Data bits 3:0 are ignored.
- R7: A hardware edge and a software write of 0 to the same flag can land on the same clock edge. In that case the flag ends set.
- R8: Request output i equals (flag i AND enable i) as it stood one clock earlier. Index i maps to flag bit 4+i. A flag set by software requests an interrupt in exactly the same way as one set by hardware.
- R9: A read with address 0x91 returns {flags, clock-control nibble}. Any other address reads 0. A write to any other address leaves the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| irqPin | input | 4 | External interrupt pins. Index i feeds flag bit 4+i. |
| irqEn | input | 4 | Per-source interrupt enables |
| clkCtlIn | input | 4 | Clock-control nibble, read back in bits 3:0 |
| busAddr | input | 8 | Special-function register address |
| busWr | input | 1 | Write strobe |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, combinational from the address |
| irqReq | output | 4 | Registered interrupt requests |

## Verification
The assertions assume the bus inputs are stable around each rising clock edge. They also assume the pins are held low during reset, so the synchronizer does not report a false edge when reset is released. The stimulus changes every input one time unit after a rising edge, and it keeps the pins low until reset has been released. Some edges are placed so that they land on the same cycle as a clearing write, and some are opposite-direction edges on each source. These cases exercise both the hardware-wins rule and the polarity filtering.

// File: rtl/extIrqPkg.sv
package extIrqPkg;
  localparam int SRC_N   = 4;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 8;
  localparam int CTL_W   = DATA_W - SRC_N;

  typedef struct packed {
    logic             wrEn;
    logic             rdEn;
    logic [SRC_N-1:0] wrFlags;
  } ctlStrobes_t;
endpackage

// File: rtl/extIrqCtl.sv
module extIrqCtl
  import extIrqPkg::*;
#(
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h91
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWdata,
  output ctlStrobes_t       strobes
);
  logic addrHit;

  always_comb begin
    addrHit         = (busAddr == REG_ADDR);
    strobes.rdEn    = addrHit;
    strobes.wrEn    = addrHit && busWr;
    strobes.wrFlags = busWdata[DATA_W-1 -: SRC_N];
  end
endmodule

// File: rtl/extIrqDatapath.sv
module extIrqDatapath
  import extIrqPkg::*;
#(
  parameter int               SYNC_STAGES  = 2,
  parameter logic [SRC_N-1:0] FALLING_MASK = 4'b1010
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [SRC_N-1:0]  irqPin,
  input  logic [SRC_N-1:0]  irqEn,
  input  logic [CTL_W-1:0]  clkCtlIn,
  input  ctlStrobes_t       strobes,
  output logic [SRC_N-1:0]  flagQ,
  output logic [DATA_W-1:0] busRdata,
  output logic [SRC_N-1:0]  irqReq
);
  logic [SRC_N-1:0] syncOut;
  logic [SRC_N-1:0] prevQ;
  logic [SRC_N-1:0] edgeHit;
  logic [SRC_N-1:0] flagD;

  for (genvar i = 0; i < SRC_N; i++) begin : g_src
    logic [SYNC_STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '0;
      else       chain <= {chain[SYNC_STAGES-2:0], irqPin[i]};
    end

    assign syncOut[i] = chain[SYNC_STAGES-1];

    if (FALLING_MASK[i]) begin : g_fall
      assign edgeHit[i] = prevQ[i] && !syncOut[i];
    end else begin : g_rise
      assign edgeHit[i] = !prevQ[i] && syncOut[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= '0;
    else       prevQ <= syncOut;
  end

  always_comb begin
    flagD = strobes.wrEn ? strobes.wrFlags : flagQ;
    flagD = flagD | edgeHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ  <= '0;
      irqReq <= '0;
    end else begin
      flagQ  <= flagD;
      irqReq <= flagQ & irqEn;
    end
  end

  always_comb begin
    busRdata = strobes.rdEn ? {flagQ, clkCtlIn} : '0;
  end
endmodule

// File: rtl/extIrqFlags.sv
module extIrqFlags
  import extIrqPkg::*;
#(
  parameter logic [ADDR_W-1:0] REG_ADDR    = 8'h91,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [SRC_N-1:0]  irqPin,
  input  logic [SRC_N-1:0]  irqEn,
  input  logic [CTL_W-1:0]  clkCtlIn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic [SRC_N-1:0]  irqReq
);
  ctlStrobes_t      strobes;
  logic [SRC_N-1:0] flagQ;
  logic             wrHit;

  extIrqCtl #(.REG_ADDR(REG_ADDR)) u_ctl (
    .busAddr (busAddr),
    .busWr   (busWr),
    .busWdata(busWdata),
    .strobes (strobes)
  );

  extIrqDatapath #(
    .SYNC_STAGES (SYNC_STAGES),
    .FALLING_MASK(4'b1010)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .irqPin  (irqPin),
    .irqEn   (irqEn),
    .clkCtlIn(clkCtlIn),
    .strobes (strobes),
    .flagQ   (flagQ),
    .busRdata(busRdata),
    .irqReq  (irqReq)
  );

  assign wrHit = strobes.wrEn;
endmodule

// File: rtl/extIrqChecker.sv
module extIrqChecker
  import extIrqPkg::*;
#(
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h91
) (
  input logic              clk,
  input logic              rstN,
  input logic [SRC_N-1:0]  flagQ,
  input logic              wrHit,
  input logic [DATA_W-1:0] busWdata,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busRdata,
  input logic [CTL_W-1:0]  clkCtlIn,
  input logic [SRC_N-1:0]  irqEn,
  input logic [SRC_N-1:0]  irqReq
);
  assert_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    !wrHit |=> ((flagQ & $past(flagQ)) == $past(flagQ)));

  assert_write_sets_R6: assert property (@(posedge clk) disable iff (!rstN)
    wrHit |=> ((flagQ & $past(busWdata[DATA_W-1 -: SRC_N])) == $past(busWdata[DATA_W-1 -: SRC_N])));

  assert_req_follows_R8: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (irqReq == $past(flagQ & irqEn)));

  assert_other_addr_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr != REG_ADDR) |-> (busRdata == '0));

  assert_read_map_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == REG_ADDR) |-> (busRdata == {flagQ, clkCtlIn}));
endmodule

bind extIrqFlags extIrqChecker #(.REG_ADDR(REG_ADDR)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .flagQ   (flagQ),
  .wrHit   (wrHit),
  .busWdata(busWdata),
  .busAddr (busAddr),
  .busRdata(busRdata),
  .clkCtlIn(clkCtlIn),
  .irqEn   (irqEn),
  .irqReq  (irqReq)
);

// File: tb/test_extIrqFlags.sv
`timescale 1ns/1ps
module test_extIrqFlags;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] ADDR = 8'h91;

  logic       clk = 0;
  logic       rstN = 0;
  logic [3:0] irqPin = 0, irqEn = 0, clkCtlIn = 4'h5;
  logic [7:0] busAddr = ADDR, busWdata = 0;
  logic       busWr = 0;
  logic [7:0] busRdata;
  logic [3:0] irqReq;

  int checks = 0, errors = 0;
  bit done = 0;

  extIrqFlags i_extIrqFlags (
    .clk(clk), .rstN(rstN), .irqPin(irqPin), .irqEn(irqEn), .clkCtlIn(clkCtlIn),
    .busAddr(busAddr), .busWr(busWr), .busWdata(busWdata),
    .busRdata(busRdata), .irqReq(irqReq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference model: pin history, sticky flags, request one clock behind.
  int pinHist[3][4];
  bit flagM[4];
  bit reqM[4];

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < 4; i++) begin
        flagM[i] = 0; reqM[i] = 0;
        for (int h = 0; h < 3; h++) pinHist[h][i] = 0;
      end
    end else begin
      for (int i = 0; i < 4; i++) begin
        bit edgeSeen;
        bit nextFlag;
        if (i % 2 == 0) edgeSeen = (pinHist[2][i] == 0) && (pinHist[1][i] == 1);
        else            edgeSeen = (pinHist[2][i] == 1) && (pinHist[1][i] == 0);
        nextFlag = (busWr && busAddr == ADDR) ? busWdata[4+i] : flagM[i];
        reqM[i]  = flagM[i] && irqEn[i];
        flagM[i] = nextFlag || edgeSeen;
        pinHist[2][i] = pinHist[1][i];
        pinHist[1][i] = pinHist[0][i];
        pinHist[0][i] = irqPin[i];
      end
    end
  end

  function automatic logic [3:0] flagVec();
    return {flagM[3], flagM[2], flagM[1], flagM[0]};
  endfunction
  function automatic logic [3:0] reqVec();
    return {reqM[3], reqM[2], reqM[1], reqM[0]};
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // Continuous comparison against the model.
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (busAddr == ADDR) check("R2 R3 R5 R6 R7 model read", busRdata, {flagVec(), clkCtlIn});
      else                 check("R9 model read other", busRdata, 8'h00);
      check("R8 model request", {4'h0, irqReq}, {4'h0, reqVec()});
    end
  end

  task automatic step(int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic sample(); @(negedge clk); endtask

  task automatic regWrite(logic [7:0] addr, logic [7:0] d);
    busAddr = addr; busWdata = d; busWr = 1;
    step();
    busWr = 0; busAddr = ADDR;
  endtask

  initial begin
    step(3);
    sample();
    check("R1 read during reset", busRdata, {4'h0, clkCtlIn});
    check("R1 request during reset", {4'h0, irqReq}, 8'h00);
    #1 rstN = 1;
    step(1);
    sample();
    check("R1 read after reset", busRdata, {4'h0, clkCtlIn});

    // R2 rising source index 0: timing.
    irqPin[0] = 1;
    step(2); sample();
    check("R2 not yet set after 2 edges", {4'h0, busRdata[7:4]}, 8'h00);
    step(1); sample();
    check("R2 rising sets bit4", {4'h0, busRdata[7:4]}, 8'h01);

    // R4 falling on rising source ignored; R5 flag stays.
    irqPin[0] = 0; step(5); sample();
    check("R4 R5 falling on rising source", {4'h0, busRdata[7:4]}, 8'h01);

    // R4 rising on falling source index 1 ignored; R3 then sets on fall.
    irqPin[1] = 1; step(5); sample();
    check("R4 rising on falling source", {4'h0, busRdata[7:4]}, 8'h01);
    irqPin[1] = 0; step(3); sample();
    check("R3 falling sets bit5", {4'h0, busRdata[7:4]}, 8'h03);

    // R3 index 3 and R2 index 2.
    irqPin[3] = 1; irqPin[2] = 1; step(4); sample();
    check("R2 rising sets bit6", {4'h0, busRdata[7:4]}, 8'h07);
    irqPin[3] = 0; step(3); sample();
    check("R3 falling sets bit7", {4'h0, busRdata[7:4]}, 8'h0F);

    // R8 requests with enables.
    irqEn = 4'b0101; step(1); sample();
    check("R8 request masked by enable", {4'h0, irqReq}, 8'h05);

    // R6 clear all, low nibble of data ignored.
    regWrite(ADDR, 8'h0F); sample();
    check("R6 write zero clears", busRdata, {4'h0, clkCtlIn});
    step(1); sample();
    check("R8 request drops after clear", {4'h0, irqReq}, 8'h00);

    // R6 R8 software set raises request.
    irqEn = 4'hF;
    regWrite(ADDR, 8'h80); sample();
    check("R6 software sets bit7", busRdata, {4'h8, clkCtlIn});
    step(1); sample();
    check("R8 software flag requests", {4'h0, irqReq}, 8'h08);

    // R9 other address: read zero, write ignored.
    busAddr = 8'h90; step(1); sample();
    check("R9 other address reads zero", busRdata, 8'h00);
    busAddr = ADDR;
    regWrite(8'h92, 8'hF0); sample();
    check("R9 write elsewhere ignored", busRdata, {4'h8, clkCtlIn});

    // R7 edge and clear collide: index 0 falls then rises.
    irqPin[2] = 0; step(4);
    irqPin[0] = 1;
    step(2);
    regWrite(ADDR, 8'h00); sample();
    check("R7 hardware set wins over clear", busRdata, {4'h1, clkCtlIn});

    clkCtlIn = 4'hA; step(1); sample();
    check("R9 low nibble passes through", busRdata, {4'h1, 4'hA});

    step(3);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule